// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block sits on the read path of a flash device and picks what a read returns while the device is busy. When nothing is running, a read returns the stored array word. When a program or erase is in progress, a read returns a status byte instead. That byte carries:

- a data-polling bit;
- two toggle bits that flip on successive reads;
- a time-limit bit;
- an erase-phase bit.

While an erase is suspended, a read either passes the array word or returns status. The choice depends on whether the read address lies in the suspended sector.

The controller that runs the embedded algorithms drives the operation code, the time-limit flag, bit 7 of the word being programmed, and a flag that says whether the current read address lies in an erasing (or erase-suspended) sector. The host read strobe advances the toggle bits. The block keeps two flip-flops of its own for the toggle bits and a delayed copy of the strobe for edge detection.

Top module: `flash_status_gen`

## Requirements
- R1: With op_code 0 (idle), rd_data equals array_data. After reset both toggle bits are 0. Codes 5 to 7 behave as idle.
- R2: With op_code 1 (program), bit 7 of rd_data is the complement of prog_d7, bit 3 is 0 and bit 2 is 1.
- R3: In op_code 1, 2 and 4, bit 6 of rd_data inverts once per rising edge of rd_strobe. The first read after the block leaves idle shows 0. A strobe held high for several cycles counts as one edge.
- R4: With op_code 2 (erase), bit 7 of rd_data is 0 and bit 3 is 1.
- R5: In op_code 2 with addr_in_erase high, bit 2 inverts on each rising edge of rd_strobe. With addr_in_erase low, bit 2 reads 1 and that read does not advance the bit-2 toggle.
- R6: With op_code 3 (erase suspended) and addr_in_erase high, bits 7 and 6 read 1 and bits 5 and 3 read 0. Bit 2 inverts on each read. Bit 6 stays 1 across reads.
- R7: With op_code 3 and addr_in_erase low, rd_data equals array_data.
- R8: With op_code 4 (program during erase suspend), the status byte follows R2, whatever the value of addr_in_erase.
- R9: In op_code 1, 2 and 4, bit 5 of rd_data equals time_limit and the other status bits keep their in-progress values. In op_code 3, bit 5 is 0.
- R10: In every status read, bits 0, 1 and 4 and all bits above 7 are 0.
- R11: One clock edge spent in idle clears both toggle bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program in suspend |
| time_limit | input | 1 | Embedded operation exceeded its time limit |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| addr_in_erase | input | 1 | Read address lies in an erasing or erase-suspended sector |
| rd_strobe | input | 1 | Host read strobe; its rising edge advances the toggle bits |
| array_data | input | DATA_W | Word read from the array at the current address |
| rd_data | output | DATA_W | Word returned to the host |

## Verification
The main function is exercised with long runs of back-to-back reads in each operation code. Each run is repeated with addr_in_erase high and low. This separates the toggle that follows the operation (bit 6) from the toggle that follows the address (bit 2), and it shows that a read of a non-erasing sector does not advance the address-sensitive toggle. A strobe held high across several clocks checks that edge detection counts one read, not one per cycle. Runs that cross through idle, and reads taken during a time-limit fault, check the toggle clearing and the time-limit bit against bits that must not move.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              time_limit,
  input  logic              prog_d7,
  input  logic              addr_in_erase,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [2:0] OP_IDLE  = 3'd0;
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_SUSP  = 3'd3;
  localparam logic [2:0] OP_SPROG = 3'd4;

  logic strobe_d, rd_edge;
  logic tog_op, tog_addr;
  logic is_prog, is_erase, is_susp, busy;
  logic show_status;
  logic [DATA_W-1:0] status;

  assign is_prog  = (op_code == OP_PROG) || (op_code == OP_SPROG);
  assign is_erase = (op_code == OP_ERASE);
  assign is_susp  = (op_code == OP_SUSP);
  assign busy     = is_prog || is_erase || is_susp;
  assign rd_edge  = rd_strobe && !strobe_d;

  assign show_status = is_prog || is_erase || (is_susp && addr_in_erase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      tog_op   <= 1'b0;
      tog_addr <= 1'b0;
    end else begin
      strobe_d <= rd_strobe;
      if (!busy) begin
        tog_op   <= 1'b0;
        tog_addr <= 1'b0;
      end else if (rd_edge) begin
        if (is_prog || is_erase)
          tog_op <= ~tog_op;
        if ((is_erase || is_susp) && addr_in_erase)
          tog_addr <= ~tog_addr;
      end
    end
  end

  always_comb begin
    status = '0;
    if (is_prog) begin
      status[7] = ~prog_d7;
      status[6] = tog_op;
      status[5] = time_limit;
      status[2] = 1'b1;
    end else if (is_erase) begin
      status[6] = tog_op;
      status[5] = time_limit;
      status[3] = 1'b1;
      status[2] = addr_in_erase ? tog_addr : 1'b1;
    end else if (is_susp) begin
      status[7] = 1'b1;
      status[6] = 1'b1;
      status[2] = tog_addr;
    end
  end

  assign rd_data = show_status ? status : array_data;

  // R1: idle and unused codes pass the array word
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (rd_data == array_data));

  // R3: bit-6 toggle only moves on a strobe edge or a return to idle
  p_op_toggle_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_op != $past(tog_op)) |-> ($past(rd_edge) || $past(!busy)));

  // R5: non-erasing sector reads during erase leave the address toggle alone
  p_addr_toggle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_erase && !addr_in_erase) |=> (tog_addr == $past(tog_addr)));

  // R9: time-limit flag visible in program and erase status
  p_time_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_prog || is_erase) && time_limit) |-> rd_data[5]);

  // R10: reserved positions stay zero in status reads
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    show_status |-> (rd_data[1:0] == 2'b00 && rd_data[4] == 1'b0));

  // R11: idle clears both toggles
  p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |=> (!tog_op && !tog_addr));

endmodule

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic time_limit = 1'b0;
  logic prog_d7 = 1'b0;
  logic addr_in_erase = 1'b0;
  logic rd_strobe = 1'b0;
  logic [W-1:0] array_data = 8'hA5;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit m6 = 1'b0;
  bit m2 = 1'b0;

  always #4 clk = ~clk;

  flash_status_gen #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .time_limit(time_limit),
    .prog_d7(prog_d7), .addr_in_erase(addr_in_erase), .rd_strobe(rd_strobe),
    .array_data(array_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_byte();
    logic [W-1:0] e = '0;
    case (op_code)
      3'd1, 3'd4: begin e[7] = ~prog_d7; e[6] = m6; e[5] = time_limit; e[2] = 1'b1; end
      3'd2: begin e[6] = m6; e[5] = time_limit; e[3] = 1'b1; e[2] = addr_in_erase ? m2 : 1'b1; end
      3'd3: begin
        if (addr_in_erase) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = m2; end
        else e = array_data;
      end
      default: e = array_data;
    endcase
    return e;
  endfunction

  task automatic do_read(output logic [W-1:0] v);
    @(negedge clk);
    rd_strobe = 1'b1;
    #2 v = rd_data;
    @(negedge clk);
    rd_strobe = 1'b0;
    if (op_code == 3'd1 || op_code == 3'd2 || op_code == 3'd4) m6 = ~m6;
    if ((op_code == 3'd2 || op_code == 3'd3) && addr_in_erase) m2 = ~m2;
  endtask

  task automatic read_chk(input string req);
    logic [W-1:0] e, v;
    @(negedge clk);
    e = expect_byte();
    do_read(v);
    chk(req, v, e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    op_code = 3'd0;
    @(negedge clk);
    m6 = 1'b0;
    m2 = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    array_data = 8'hA5;
    do_read(v);
    chk("R1 idle read after reset", v, 8'hA5);
    array_data = 8'h3C;
    op_code = 3'd6;
    do_read(v);
    chk("R1 unused code passes data", v, 8'h3C);
    go_idle();
  endtask

  task automatic t_program();
    logic [W-1:0] v, w;
    op_code = 3'd1; prog_d7 = 1'b1;
    do_read(v);
    chk("R3 first program read toggle 0 / R2 R10", v, 8'h04);
    do_read(v);
    chk("R3 second program read toggles", v, 8'h44);
    prog_d7 = 1'b0;
    read_chk("R2 complement of bit 7");
    @(negedge clk); rd_strobe = 1'b1;
    repeat (4) @(negedge clk);
    rd_strobe = 1'b0;
    m6 = ~m6;
    read_chk("R3 held strobe counts once");
    do_read(v);
    do_read(w);
    chk("R3 bit6 differs on consecutive reads", v[6] ^ w[6], 8'h01);
    go_idle();
    op_code = 3'd1; prog_d7 = 1'b1;
    do_read(v);
    chk("R11 toggle cleared after idle", v, 8'h04);
    go_idle();
  endtask

  task automatic t_erase();
    logic [W-1:0] v;
    op_code = 3'd2; addr_in_erase = 1'b1;
    do_read(v);
    chk("R4 R5 erase first read", v, 8'h08);
    do_read(v);
    chk("R5 erase second read toggles bit2 and bit6", v, 8'h4C);
    read_chk("R5 erase third read");
    addr_in_erase = 1'b0;
    read_chk("R5 non-erasing sector bit2 one");
    read_chk("R5 non-erasing sector again");
    addr_in_erase = 1'b1;
    read_chk("R5 address toggle kept through other-sector reads");
    go_idle();
  endtask

  task automatic t_suspend();
    logic [W-1:0] v, w;
    op_code = 3'd2; addr_in_erase = 1'b1;
    read_chk("R5 erase before suspend");
    op_code = 3'd3;
    read_chk("R6 suspended sector status");
    do_read(v);
    do_read(w);
    chk("R6 bit6 stays 1", {v[6], w[6]}, 8'h03);
    chk("R6 bit2 toggles", v[2] ^ w[2], 8'h01);
    chk("R6 fixed bits", {v[7], v[5], v[3]}, 8'h04);
    addr_in_erase = 1'b0; array_data = 8'h5A;
    do_read(v);
    chk("R7 other sector passes data", v, 8'h5A);
    op_code = 3'd4; prog_d7 = 1'b1; addr_in_erase = 1'b1;
    read_chk("R8 program in suspend");
    addr_in_erase = 1'b0; prog_d7 = 1'b0;
    read_chk("R8 program in suspend other sector");
    go_idle();
  endtask

  task automatic t_timeout();
    time_limit = 1'b1;
    op_code = 3'd1; prog_d7 = 1'b1;
    read_chk("R9 program time limit");
    read_chk("R9 program time limit toggles");
    go_idle();
    op_code = 3'd2; addr_in_erase = 1'b1;
    read_chk("R9 erase time limit keeps bit3");
    go_idle();
    op_code = 3'd4;
    read_chk("R9 suspend program time limit");
    op_code = 3'd3;
    read_chk("R9 suspended sector ignores time limit / R10");
    time_limit = 1'b0;
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_timeout();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule